// File: doc/BRIEF.md
# Serial Word Transmitter with Loopback Steering

This block turns a stream of 20-bit parallel words into a serial bit stream. Each word holds two 10-bit line characters that are already coded. A bit-rate clock enable marks every bit slot on the single fast clock. An internal divide-by-20 counter tells the block when to take in the next word, which it signals on a one-cycle strobe. The word is then shifted out one bit per enabled slot, with no idle slot between words. The serial rate is therefore twenty times the word rate.

A wrap control takes the line out of service. While wrap is in force, the differential line output is parked at a steady logic one (true side high, complement side low). The serialized stream then goes to a separate loopback output that feeds a local receiver. The block samples wrap only when it takes in a word, so every word appears complete on exactly one of the two outputs.

Top module: `ser_wrap_tx`

## Requirements
- R1: After synchronous reset, and until the first enabled bit slot, line_p is 0, line_n is 1 and loop_out is 0.
- R2: word_take is high in exactly the cycles where bit_en is high and the slot starts a word. The first bit_en after reset starts a word, and every 20th enabled slot after that does too. word_in is captured on that clock edge only.
- R3: The bits of a captured word leave in order from bit 0 to bit 19, one per enabled slot. Bit k is visible on the active output from the clock edge of the k-th enabled slot of that word (counting from 0) until the next enabled slot.
- R4: Words follow each other with no gap. The enabled slot after bit 19 of one word carries bit 0 of the next word.
- R5: Bits 0..9 hold the first 10-bit character and bits 10..19 the second. The whole first character leaves before any bit of the second, and each character leaves lowest bit first.
- R6: With wrap in force for a word, line_p is 1 and line_n is 0 for all 20 slots of that word, and loop_out carries that word's bits.
- R7: With wrap off for a word, line_p carries that word's bits and loop_out stays 0.
- R8: wrap_en is sampled only in the word_take cycle. A change in the middle of a word has no effect until the next word starts.
- R9: When bit_en is low, line_p, line_n and loop_out keep their values.
- R10: line_n is always the complement of line_p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-slot enable, one pulse per serial bit |
| word_in | input | 20 | Parallel word of two coded characters |
| wrap_en | input | 1 | Wrap request; line parked high, stream to loopback |
| word_take | output | 1 | High in the cycle where word_in is captured |
| line_p | output | 1 | Serial line, true side |
| line_n | output | 1 | Serial line, complement side |
| loop_out | output | 1 | Internal loopback serial stream |

## Verification
A slot counter that is off by one shows at the ports in two ways. word_take arrives at the wrong slot, and the bits of the next word come out rotated. Both appear within one word of the error.

A shift register that loses or repeats a bit corrupts the line pattern in the very next enabled slot. A stale wrap mode puts data on the wrong output. The bench captures that at the first slot of the affected word, or in mid-word when wrap is toggled.

// File: rtl/ser_pkg.sv
package ser_pkg;
   typedef enum logic {
      MODE_LINE = 1'b0,
      MODE_WRAP = 1'b1
   } tx_mode_e;

   function automatic int clog2_min1(input int n);
      int r;
      r = 0;
      while ((1 << r) < n) r++;
      return (r < 1) ? 1 : r;
   endfunction
endpackage

// File: rtl/ser_slot_cnt.sv
module ser_slot_cnt #(
   parameter int SLOTS = 20
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   output logic start
);
   localparam int CW = ser_pkg::clog2_min1(SLOTS);
   localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

   generate
      if (SLOTS < 2) begin : g_bad
         $error("ser_slot_cnt: SLOTS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign start = bit_en && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (bit_en) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
   parameter int WORD_W    = 20,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   output logic              nxt_bit
);
   localparam int RW = WORD_W - 1;

   generate
      if (WORD_W < 2) begin : g_bad
         $error("ser_shifter: WORD_W must be at least 2");
      end
   endgenerate

   logic [RW-1:0] rest_q;
   logic [RW-1:0] rest_d;
   logic          head;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign head = load ? word[0] : rest_q[0];
         always_comb begin
            if (load) rest_d = word[WORD_W-1:1];
            else      rest_d = {1'b0, rest_q[RW-1:1]};
         end
      end else begin : g_msb
         assign head = load ? word[WORD_W-1] : rest_q[RW-1];
         always_comb begin
            if (load) rest_d = word[WORD_W-2:0];
            else      rest_d = {rest_q[RW-2:0], 1'b0};
         end
      end
   endgenerate

   assign nxt_bit = head;

   always_ff @(posedge clk) begin
      if (rst)         rest_q <= '0;
      else if (bit_en) rest_q <= rest_d;
   end
endmodule

// File: rtl/ser_route.sv
module ser_route (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic start,
   input  logic wrap_req,
   input  logic bit_in,
   output logic wrap_act,
   output logic line_p,
   output logic line_n,
   output logic loop_o
);
   import ser_pkg::*;

   tx_mode_e mode_q;
   tx_mode_e mode_now;
   logic     lp_q, ln_q, lb_q;

   assign mode_now = start ? tx_mode_e'(wrap_req) : mode_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MODE_LINE;
         lp_q   <= 1'b0;
         ln_q   <= 1'b1;
         lb_q   <= 1'b0;
      end else if (bit_en) begin
         mode_q <= mode_now;
         if (mode_now == MODE_WRAP) begin
            lp_q <= 1'b1;
            ln_q <= 1'b0;
            lb_q <= bit_in;
         end else begin
            lp_q <= bit_in;
            ln_q <= ~bit_in;
            lb_q <= 1'b0;
         end
      end
   end

   assign wrap_act = (mode_q == MODE_WRAP);
   assign line_p   = lp_q;
   assign line_n   = ln_q;
   assign loop_o   = lb_q;
endmodule

// File: rtl/ser_wrap_tx.sv
module ser_wrap_tx #(
   parameter int CHAR_W    = 10,
   parameter int CHARS     = 2,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    bit_en,
   input  logic [CHAR_W*CHARS-1:0] word_in,
   input  logic                    wrap_en,
   output logic                    word_take,
   output logic                    line_p,
   output logic                    line_n,
   output logic                    loop_out
);
   localparam int WORD_W = CHAR_W * CHARS;

   generate
      if (CHAR_W < 1 || CHARS < 1 || WORD_W < 2) begin : g_bad
         $error("ser_wrap_tx: word must hold at least two bits");
      end
   endgenerate

   logic start;
   logic nbit;
   logic wrap_act;

   ser_slot_cnt #(.SLOTS(WORD_W)) u_cnt (
      .clk(clk), .rst(rst), .bit_en(bit_en), .start(start)
   );

   ser_shifter #(.WORD_W(WORD_W), .LSB_FIRST(LSB_FIRST)) u_shf (
      .clk(clk), .rst(rst), .bit_en(bit_en), .load(start),
      .word(word_in), .nxt_bit(nbit)
   );

   ser_route u_rt (
      .clk(clk), .rst(rst), .bit_en(bit_en), .start(start),
      .wrap_req(wrap_en), .bit_in(nbit), .wrap_act(wrap_act),
      .line_p(line_p), .line_n(line_n), .loop_o(loop_out)
   );

   assign word_take = start;
endmodule

// File: rtl/ser_wrap_tx_chk.sv
module ser_wrap_tx_chk #(
   parameter int WORD_W = 20
) (
   input logic clk,
   input logic rst,
   input logic bit_en,
   input logic wrap_en,
   input logic word_take,
   input logic line_p,
   input logic line_n,
   input logic loop_out,
   input logic wrap_act
);
   int   since_q;
   logic seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_q <= 0;
         seen_q  <= 1'b0;
      end else if (bit_en) begin
         if (word_take) begin
            since_q <= 0;
            seen_q  <= 1'b1;
         end else begin
            since_q <= since_q + 1;
         end
      end
   end

   // R2: word start every WORD_W enabled slots
   a_r2_take_due: assert property (@(posedge clk) disable iff (rst)
      (bit_en && seen_q && since_q == WORD_W - 1) |-> word_take);
   a_r2_take_only_due: assert property (@(posedge clk) disable iff (rst)
      word_take |-> (bit_en && (!seen_q || since_q == WORD_W - 1)));
   // R1: quiet line right after reset
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!line_p && line_n && !loop_out));
   // R6: wrapped word parks the line high
   a_r6_wrap_line_high: assert property (@(posedge clk) disable iff (rst)
      (bit_en && word_take && wrap_en) |=> (line_p && !line_n));
   // R7: loopback silent in line mode
   a_r7_loop_quiet: assert property (@(posedge clk) disable iff (rst)
      !wrap_act |-> !loop_out);
   // R8: mode only changes at a word start
   a_r8_mode_at_start: assert property (@(posedge clk) disable iff (rst)
      !word_take |=> $stable(wrap_act));
   // R9: no change without an enabled slot
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> ($stable(line_p) && $stable(loop_out)));
   // R10: complementary line
   a_r10_compl: assert property (@(posedge clk) disable iff (rst)
      line_n == !line_p);
endmodule

bind ser_wrap_tx ser_wrap_tx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst(rst), .bit_en(bit_en), .wrap_en(wrap_en),
   .word_take(word_take), .line_p(line_p), .line_n(line_n),
   .loop_out(loop_out), .wrap_act(wrap_act)
);

// File: tb/sim_ser_wrap_tx.sv
module sim_ser_wrap_tx;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bit_en = 1'b0;
   logic [19:0] word_in = '0;
   logic        wrap_en = 1'b0;
   logic        word_take, line_p, line_n, loop_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   ser_wrap_tx u0 (
      .clk(clk), .rst(rst), .bit_en(bit_en), .word_in(word_in),
      .wrap_en(wrap_en), .word_take(word_take), .line_p(line_p),
      .line_n(line_n), .loop_out(loop_out)
   );

   task automatic chk(input string req, input string what,
                      input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic chk_outs(input string req, input logic wrap, input logic b);
      chk(wrap ? "R6" : req, "line_p", line_p, wrap ? 1'b1 : b);
      chk("R10", "line_n", line_n, !line_p);
      chk(wrap ? req : "R7", "loop_out", loop_out, wrap ? b : 1'b0);
   endtask

   // one whole word; called at a negedge, returns at a negedge
   task automatic run_word(input logic [19:0] w, input logic wr0,
                           input logic wr_mid, input int gap,
                           input string req);
      for (int i = 0; i < 20; i++) begin
         bit_en  = 1'b1;
         word_in = (i == 0) ? w : ~w;       // R2: only take-cycle value counts
         wrap_en = (i < 10) ? wr0 : wr_mid; // R8: mid-word change ignored
         #1;
         chk("R2", "word_take", word_take, i == 0);
         @(negedge clk);
         chk_outs(req, wr0, w[i]);
         for (int g = 0; g < gap; g++) begin
            bit_en = 1'b0;
            #1;
            chk("R2", "word_take idle", word_take, 1'b0);
            @(negedge clk);
            chk_outs("R9", wr0, w[i]);
         end
      end
      bit_en = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R1", "line_p", line_p, 1'b0);
         chk("R1", "line_n", line_n, 1'b1);
         chk("R1", "loop_out", loop_out, 1'b0);
      end
   endtask

   task automatic t_order();
      run_word(20'hA5C3E, 1'b0, 1'b0, 0, "R3");
      run_word(20'h0F0F1, 1'b0, 1'b0, 0, "R3");
   endtask

   task automatic t_back_to_back();
      run_word(20'hFFFFF, 1'b0, 1'b0, 0, "R4");
      run_word(20'h00000, 1'b0, 1'b0, 0, "R4");
      run_word(20'h80001, 1'b0, 1'b0, 0, "R4");
   endtask

   task automatic t_chars();
      // low char bits0..6 = 0,0,1,1,1,1,1 ; high char all alternating
      run_word({10'b1010101010, 10'b1001111100}, 1'b0, 1'b0, 0, "R5");
   endtask

   task automatic t_wrap();
      run_word(20'h3C5A9, 1'b1, 1'b1, 0, "R6");
      run_word(20'h12345, 1'b1, 1'b1, 1, "R6");
   endtask

   task automatic t_wrap_mid();
      run_word(20'h6B2D4, 1'b0, 1'b1, 0, "R8");
      run_word(20'h9E0C7, 1'b1, 1'b0, 0, "R8");
      run_word(20'h55AA3, 1'b0, 1'b0, 0, "R8");
   endtask

   task automatic t_stall();
      run_word(20'hC0FFE, 1'b0, 1'b0, 2, "R9");
      run_word(20'h7D3B1, 1'b1, 1'b1, 3, "R9");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_order();
      t_back_to_back();
      t_chars();
      t_wrap();
      t_wrap_mid();
      t_stall();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule